// File: doc/BRIEF.md
# Receive Symbol Order Aligner

This block follows a receive deserializer that packs two line symbols into one word per clock. The reset timing of the receive logic is not fixed, so the two symbols of each word may come out swapped relative to the transmitted stream. The block searches the incoming words for a programmable ordering pattern. When the pattern is found in the upper slot, the block inserts one pad symbol into the stream. Every later symbol then moves by one slot, so the next occurrence of the pattern starts in slot 0. When the pattern already sits in slot 0, the data passes through unchanged.

The symbol width is a parameter: 8 bits for plain byte data, 10 bits for raw line code, or 9 bits for decoded data with a control flag. The pattern is one symbol long or two symbols long. An ordering attempt starts in one of two ways. In request mode, software or a controller supplies a rising edge on a request input. In automatic mode, the attempt runs whenever the upstream word aligner reports lock and ordering is not yet done. A done flag reports that a correct position has been seen and the correction is in force.

Top module: `rx_sym_order`

## Requirements
- R1: During synchronous reset (active low), `dout_o` is all zeros and `order_done_o` is 0. After reset the block passes data through with no shift.
- R2: While no shift is in force, `dout_o` equals `din_i` of the previous cycle. The latency is one clock.
- R3: Slot 0 is `din_i[SYM_W-1:0]` and is the earlier symbol in stream order; slot 1 is the upper symbol. Suppose an attempt is active and a single-symbol pattern (`order_pat_i`) appears in slot 0. Then the word passes unchanged and `order_done_o` is 1 from the next cycle on.
- R4: Suppose an attempt is active and the pattern appears in slot 1 only. The output word for that input is {pad, slot 0}. From then on, each output word is {current slot 0, previous slot 1}. `order_done_o` rises at the same time.
- R5: If the same input word holds the pattern in both slots, the slot 0 match wins. No pad is inserted and no shift is taken.
- R6: In request mode (`auto_mode_i`=0) with no armed attempt, patterns in either slot have no effect: the data passes unchanged and `order_done_o` stays 0.
- R7: In request mode, a rising edge on `order_req_i` seen while `align_lock_i`=1 does three things. It clears `order_done_o`, drops any shift (the pass-through starts on the next word), and arms exactly one attempt. Once that attempt succeeds, later pattern sightings are ignored.
- R8: In automatic mode (`auto_mode_i`=1), an attempt is active whenever `align_lock_i`=1 and `order_done_o`=0. While `align_lock_i`=0, no ordering takes place in either mode.
- R9: A cycle with `align_lock_i`=0 clears `order_done_o` and any shift. The pass-through starts from the following word.
- R10: With `PAT_SYMS`=2, `order_pat_i` holds the first symbol in its low half and the second in its high half. A match in slot 0 means {second, first} in one word. A match in slot 1 means the first symbol in slot 1 followed by the second in slot 0 of the next word. In that case the pad is inserted in the cycle the second symbol arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| auto_mode_i | input | 1 | 1 = attempts driven by aligner lock, 0 = attempts on request edge |
| order_req_i | input | 1 | Request input; a rising edge arms one attempt in request mode |
| align_lock_i | input | 1 | Word aligner lock status |
| order_pat_i | input | PAT_SYMS*SYM_W | Ordering pattern; low symbol comes first in stream order |
| pad_sym_i | input | SYM_W | Symbol inserted to shift the order |
| din_i | input | 2*SYM_W | Two-symbol word from the deserializer |
| dout_o | output | 2*SYM_W | Reordered two-symbol word, one cycle later |
| order_done_o | output | 1 | Ordering achieved and held |

## Verification
Two searches run on every word: the match in slot 0 and the match in slot 1. Both can succeed in the same cycle when a word carries the pattern in both slots. The bench arms an attempt and then feeds exactly such a word. It expects that word unchanged on the output and `order_done_o` set. It also expects the next word unshifted, which shows that no pad was inserted. The bench also applies a request edge while a shift is in force. In that cycle the output must still show the shifted word, and the done flag must drop.

// File: rtl/rx_sym_order_pkg.sv
// Shared types for the receive symbol order aligner.
// Assumes nothing beyond being compiled before the modules that import it.
package rx_sym_order_pkg;

    // Output word selection made by the controller each cycle.
    typedef enum logic [1:0] {
        SEL_PASS  = 2'd0,   // word passes as received
        SEL_PAD   = 2'd1,   // pad symbol enters slot 1, shift starts
        SEL_SHIFT = 2'd2    // shift in force: {slot 0, previous slot 1}
    } ord_sel_e;

endpackage

// File: rtl/rx_sym_order_detect.sv
// Pattern search over the current word and the previous upper symbol.
// Raises hit_here_o when the pattern starts in slot 0 of this word and
// hit_late_o when it starts one symbol position earlier (in slot 1).
// Assumes PAT_SYMS is 1 or 2 and prev_s1_i is last cycle's upper symbol.
module rx_sym_order_detect #(
    parameter int SYM_W    = 10,
    parameter int PAT_SYMS = 1
) (
    input  logic [2*SYM_W-1:0]        din_i,
    input  logic [SYM_W-1:0]          prev_s1_i,
    input  logic [PAT_SYMS*SYM_W-1:0] pat_i,
    output logic                      hit_here_o,
    output logic                      hit_late_o
);
    localparam int W2 = 2 * SYM_W;

    logic [SYM_W-1:0] s0, s1;
    assign s0 = din_i[SYM_W-1:0];
    assign s1 = din_i[W2-1:SYM_W];

    generate
        if (PAT_SYMS == 1) begin : g_one
            logic unused_prev;
            assign unused_prev = ^prev_s1_i;
            // Single symbol: compare each slot on its own.
            assign hit_here_o = (s0 == pat_i);
            assign hit_late_o = (s1 == pat_i);
        end else begin : g_two
            logic [SYM_W-1:0] p_first, p_second;
            assign p_first  = pat_i[SYM_W-1:0];
            assign p_second = pat_i[2*SYM_W-1:SYM_W];
            // Two symbols: in-word pair, or pair straddling the word edge.
            assign hit_here_o = (s0 == p_first) && (s1 == p_second);
            assign hit_late_o = (prev_s1_i == p_first) && (s0 == p_second);
        end
    endgenerate

endmodule

// File: rtl/rx_sym_order_ctrl.sv
// Attempt control: arming by request edge or by lock, success tracking,
// shift state and the per-cycle word selection.
// Assumes hit inputs are combinational from the current word.
module rx_sym_order_ctrl
    import rx_sym_order_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     auto_i,
    input  logic     req_i,
    input  logic     lock_i,
    input  logic     hit_here_i,
    input  logic     hit_late_i,
    output ord_sel_e sel_o,
    output logic     done_o
);
    logic req_q, armed_q, done_q, shift_q;
    logic req_rise, rearm, seeking, take_here, take_late;

    // Decide this cycle's attempt outcome; slot 0 match has priority.
    always_comb begin
        req_rise  = req_i & ~req_q;
        rearm     = ~auto_i & req_rise;
        seeking   = auto_i ? ~done_q : armed_q;
        take_here = lock_i & ~rearm & seeking & hit_here_i;
        take_late = lock_i & ~rearm & seeking & ~hit_here_i & hit_late_i;
    end

    // Select the output word form.
    always_comb begin
        if (take_late)    sel_o = SEL_PAD;
        else if (shift_q) sel_o = SEL_SHIFT;
        else              sel_o = SEL_PASS;
    end

    // Track request edge, arming, success and shift state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q   <= 1'b0;
            armed_q <= 1'b0;
            done_q  <= 1'b0;
            shift_q <= 1'b0;
        end else begin
            req_q <= req_i;
            if (!lock_i) begin
                armed_q <= 1'b0;
                done_q  <= 1'b0;
                shift_q <= 1'b0;
            end else if (rearm) begin
                armed_q <= 1'b1;
                done_q  <= 1'b0;
                shift_q <= 1'b0;
            end else if (take_here) begin
                armed_q <= 1'b0;
                done_q  <= 1'b1;
            end else if (take_late) begin
                armed_q <= 1'b0;
                done_q  <= 1'b1;
                shift_q <= 1'b1;
            end
        end
    end

    assign done_o = done_q;

    assert_lock_loss_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_i |=> (!done_q && !shift_q));

    assert_rearm_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rearm && lock_i |=> (!done_q && !shift_q && armed_q));

    assert_shift_needs_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        shift_q |-> done_q);

    assert_done_needs_lock_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_q) |-> $past(lock_i));

endmodule

// File: rtl/rx_sym_order_mux.sv
// Output datapath: registers the reordered word and keeps the previous
// upper symbol for both the shift path and the straddling pattern search.
// Assumes sel_i is valid every cycle.
module rx_sym_order_mux
    import rx_sym_order_pkg::*;
#(
    parameter int SYM_W = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  ord_sel_e             sel_i,
    input  logic [2*SYM_W-1:0]   din_i,
    input  logic [SYM_W-1:0]     pad_i,
    output logic [SYM_W-1:0]     prev_s1_o,
    output logic [2*SYM_W-1:0]   dout_o
);
    localparam int W2 = 2 * SYM_W;

    logic [SYM_W-1:0] s1_q;
    logic [W2-1:0]    dout_q;

    // Hold last upper symbol and build the output word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q   <= '0;
            dout_q <= '0;
        end else begin
            s1_q <= din_i[W2-1:SYM_W];
            case (sel_i)
                SEL_PAD:   dout_q <= {pad_i, din_i[SYM_W-1:0]};
                SEL_SHIFT: dout_q <= {din_i[SYM_W-1:0], s1_q};
                default:   dout_q <= din_i;
            endcase
        end
    end

    assign prev_s1_o = s1_q;
    assign dout_o    = dout_q;

    assert_pass_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == SEL_PASS |=> dout_o == $past(din_i));

    assert_pad_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        sel_i == SEL_PAD |=> dout_o[W2-1:SYM_W] == $past(pad_i));

endmodule

// File: rtl/rx_sym_order.sv
// Receive symbol order aligner top. Two symbols per word, slot 0 first.
// Finds the ordering pattern and inserts one pad symbol when it sits in
// slot 1, so later occurrences start in slot 0. Latency is one clock.
// Assumes a continuous word stream (no valid qualifier) and PAT_SYMS 1 or 2.
module rx_sym_order #(
    parameter int SYM_W    = 10,
    parameter int PAT_SYMS = 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      auto_mode_i,
    input  logic                      order_req_i,
    input  logic                      align_lock_i,
    input  logic [PAT_SYMS*SYM_W-1:0] order_pat_i,
    input  logic [SYM_W-1:0]          pad_sym_i,
    input  logic [2*SYM_W-1:0]        din_i,
    output logic [2*SYM_W-1:0]        dout_o,
    output logic                      order_done_o
);
    import rx_sym_order_pkg::*;

    logic [SYM_W-1:0] prev_s1;
    logic             hit_here, hit_late;
    ord_sel_e         sel;

    rx_sym_order_detect #(.SYM_W(SYM_W), .PAT_SYMS(PAT_SYMS)) u_detect (
        .din_i      (din_i),
        .prev_s1_i  (prev_s1),
        .pat_i      (order_pat_i),
        .hit_here_o (hit_here),
        .hit_late_o (hit_late)
    );

    rx_sym_order_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .auto_i     (auto_mode_i),
        .req_i      (order_req_i),
        .lock_i     (align_lock_i),
        .hit_here_i (hit_here),
        .hit_late_i (hit_late),
        .sel_o      (sel),
        .done_o     (order_done_o)
    );

    rx_sym_order_mux #(.SYM_W(SYM_W)) u_mux (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_i     (sel),
        .din_i     (din_i),
        .pad_i     (pad_sym_i),
        .prev_s1_o (prev_s1),
        .dout_o    (dout_o)
    );

    assert_aligned_no_pad_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_here && !order_done_o) |=> dout_o == $past(din_i));

endmodule

// File: tb/rx_sym_order_tb.sv
// Directed bench: one task per scenario; each task checks its own results.
module rx_sym_order_tb;
    localparam int  CLK_PERIOD = 10;
    localparam int  SW = 10;
    localparam logic [SW-1:0] P   = 10'h17C;
    localparam logic [SW-1:0] PB  = 10'h283;
    localparam logic [SW-1:0] PAD = 10'h0F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic auto_mode = 1'b0;
    logic req = 1'b0;
    logic lock = 1'b0;
    logic [2*SW-1:0] din = '0;
    logic [2*SW-1:0] dout1, dout2;
    logic done1, done2;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rx_sym_order #(.SYM_W(SW), .PAT_SYMS(1)) u_dut (
        .clk(clk), .rst_n(rst_n), .auto_mode_i(auto_mode), .order_req_i(req),
        .align_lock_i(lock), .order_pat_i(P), .pad_sym_i(PAD), .din_i(din),
        .dout_o(dout1), .order_done_o(done1)
    );

    rx_sym_order #(.SYM_W(SW), .PAT_SYMS(2)) u_dut2 (
        .clk(clk), .rst_n(rst_n), .auto_mode_i(auto_mode), .order_req_i(req),
        .align_lock_i(lock), .order_pat_i({PB, P}), .pad_sym_i(PAD), .din_i(din),
        .dout_o(dout2), .order_done_o(done2)
    );

    function automatic logic [2*SW-1:0] w(input logic [SW-1:0] s1, input logic [SW-1:0] s0);
        return {s1, s0};
    endfunction

    // Drive one word at the falling edge, check the result after the rising edge.
    task automatic step(input bit second, input logic [2*SW-1:0] word,
                        input logic [2*SW-1:0] exp, input logic exp_done,
                        input string tag);
        logic [2*SW-1:0] got;
        logic got_done;
        @(negedge clk);
        din = word;
        @(posedge clk);
        #1;
        got      = second ? dout2 : dout1;
        got_done = second ? done2 : done1;
        total++;
        if (got !== exp || got_done !== exp_done) begin
            bad++;
            $display("FAIL %s: dout=%h done=%b expected dout=%h done=%b",
                     tag, got, got_done, exp, exp_done);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        din = w(10'h3FF, 10'h155);
        repeat (3) @(posedge clk);
        #1;
        total++;
        if (dout1 !== '0 || done1 !== 1'b0) begin
            bad++;
            $display("FAIL R1: dout=%h done=%b expected dout=0 done=0", dout1, done1);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_manual_idle();
        auto_mode = 1'b0; lock = 1'b1; req = 1'b0;
        step(0, w(P, 10'd1),  w(P, 10'd1),  1'b0, "R6 slot1 pattern ignored");
        step(0, w(10'd2, 10'd3), w(10'd2, 10'd3), 1'b0, "R2 pass-through");
        step(0, w(10'd4, P),  w(10'd4, P),  1'b0, "R6 slot0 pattern ignored");
    endtask

    task automatic t_manual_late();
        req = 1'b1;
        step(0, w(10'd5, 10'd6), w(10'd5, 10'd6), 1'b0, "R7 arm on edge");
        step(0, w(P, 10'd7),  w(PAD, 10'd7), 1'b1, "R4 pad inserted");
        step(0, w(10'd8, 10'd9), w(10'd9, P), 1'b1, "R4 shifted word");
        step(0, w(P, 10'd10), w(10'd10, 10'd8), 1'b1, "R7 single attempt");
        step(0, w(10'd11, 10'd12), w(10'd12, P), 1'b1, "R4 shift held");
    endtask

    task automatic t_rearm_aligned();
        req = 1'b0;
        step(0, w(10'd13, 10'd14), w(10'd14, 10'd11), 1'b1, "R7 level no rearm");
        req = 1'b1;
        step(0, w(10'd15, 10'd16), w(10'd16, 10'd13), 1'b0, "R7 rearm clears done");
        step(0, w(10'd17, 10'd18), w(10'd17, 10'd18), 1'b0, "R7 shift dropped");
        step(0, w(10'd19, P),  w(10'd19, P),  1'b1, "R3 aligned match");
        step(0, w(P, 10'd20),  w(P, 10'd20),  1'b1, "R3 held after success");
    endtask

    task automatic t_both_slots();
        req = 1'b0;
        step(0, w(10'd21, 10'd22), w(10'd21, 10'd22), 1'b1, "R5 setup");
        req = 1'b1;
        step(0, w(10'd23, 10'd24), w(10'd23, 10'd24), 1'b0, "R5 arm");
        step(0, w(P, P), w(P, P), 1'b1, "R5 both slots, slot0 wins");
        step(0, w(10'd25, 10'd26), w(10'd25, 10'd26), 1'b1, "R5 no shift after");
    endtask

    task automatic t_auto_lock();
        req = 1'b0; auto_mode = 1'b1; lock = 1'b0;
        step(0, w(P, 10'd27), w(P, 10'd27), 1'b0, "R8 no ordering without lock");
        step(0, w(P, 10'd28), w(P, 10'd28), 1'b0, "R8 still unlocked");
        lock = 1'b1;
        step(0, w(P, 10'd29), w(PAD, 10'd29), 1'b1, "R8 auto pad on lock");
        step(0, w(10'd30, 10'd31), w(10'd31, P), 1'b1, "R8 auto shifted");
        lock = 1'b0;
        step(0, w(10'd32, 10'd33), w(10'd33, 10'd30), 1'b0, "R9 lock loss clears done");
        step(0, w(10'd34, 10'd35), w(10'd34, 10'd35), 1'b0, "R9 shift cleared");
        lock = 1'b1;
        step(0, w(10'd36, 10'd37), w(10'd36, 10'd37), 1'b0, "R8 seeking, no pattern");
    endtask

    task automatic t_two_sym();
        auto_mode = 1'b1; lock = 1'b1; req = 1'b0;
        do_reset();
        step(1, w(P, 10'd40), w(P, 10'd40), 1'b0, "R10 first half only");
        step(1, w(10'd41, PB), w(PAD, PB), 1'b1, "R10 straddling pair pad");
        step(1, w(10'd42, 10'd43), w(10'd43, 10'd41), 1'b1, "R10 shifted");
        do_reset();
        step(1, w(PB, P), w(PB, P), 1'b1, "R10 in-word pair");
        step(1, w(10'd44, 10'd45), w(10'd44, 10'd45), 1'b1, "R10 no shift");
    endtask

    initial begin
        do_reset();
        t_manual_idle();
        t_manual_late();
        t_rearm_aligned();
        t_both_slots();
        t_auto_lock();
        t_two_sym();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule